// File: doc/BRIEF.md
# TDM Quadrant Channel Bit Override

This block sits in the receive datapath of a time-division multiplexed voice switch. It sees each 8-bit channel byte as it arrives. With the byte come the number of the stream that carried it, the channel's position in the frame and the line rate of that stream. The frame of each rate is split into four equal quarters. For every stream and every quarter, a 3-bit code either passes the byte through or forces its most significant or least significant bit to a fixed value. The changed byte appears, registered, one clock after its input strobe.

Each stream has its own control word, held in a bank of 32 registers. A synchronous read/write port reaches the bank in a window of consecutive addresses. Software sets a code to insert signalling or marker bits into a chosen part of a frame, for example an idle pattern on one quarter of the channels. It does this without touching the switching memory.

Top module: `tdmq_bit_override`

## Requirements
- R1: After reset every control word is zero, `out_vld` is low and every read of the window returns 0x0000.
- R2: The control word of stream n sits at address 0x0120 + n (0x0120 to 0x013F). A write stores bits [11:0]. A read returns them, with bits [15:12] always zero.
- R3: A read of any address outside 0x0120 to 0x013F returns zero. A write there changes no control word.
- R4: Quadrant q is controlled by word bits [3q+2:3q]. Quadrant 0 uses [2:0], quadrant 1 [5:3], quadrant 2 [8:6] and quadrant 3 [11:9].
- R5: A quadrant code with bit 2 clear (0xx) passes the byte unchanged.
- R6: Code 100 forces byte bit 7 to 0 and code 101 forces it to 1. Bits 6 to 0 are unchanged.
- R7: Code 110 forces byte bit 0 to 0 and code 111 forces it to 1. Bits 7 to 1 are unchanged.
- R8: `in_rate` 0, 1, 2 and 3 select frames of 32, 64, 128 and 256 channels. Each quadrant holds 8, 16, 32 or 64 channels. The quadrant number is `in_chan` divided by that count, so quadrant 1 covers 8 to 15, 16 to 31, 32 to 63 and 64 to 127.
- R9: A channel index at or beyond the frame length of its rate passes the byte unchanged.
- R10: `out_vld` equals `in_vld` delayed by one clock. `out_byte` is the result for the byte strobed one clock earlier.
- R11: A write that shares a clock edge with a strobe does not affect that strobe. Every later strobe uses the new word. The word applies only to the stream it belongs to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 16 | Register port address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 16 | Register write data |
| reg_re | input | 1 | Register read enable; `reg_rdata` updates on the next edge |
| reg_rdata | output | 16 | Registered read data |
| in_vld | input | 1 | Channel byte strobe |
| in_stream | input | 5 | Stream number of the byte |
| in_chan | input | 8 | Channel index within the frame |
| in_rate | input | 2 | Rate mode, 0 to 3 as in R8 |
| in_byte | input | 8 | Channel byte |
| out_vld | output | 1 | Output strobe |
| out_byte | output | 8 | Possibly modified byte |

## Verification
The bench probes the first and last channel of every quadrant at every rate. A design with a wrong shift would fault exactly these edges, applying a neighbour's code one channel early or late. It sends channels just past the frame end, which a design that wraps the index would modify. It sweeps all eight codes on both all-zero and all-one bytes, so a swapped MSB/LSB or an inverted force value shows up at once. It also issues a write and a strobe on the same edge. A bypassed register path would apply the new code one strobe too soon. Reads just below and above the window, and a write above it, expose a decoder that aliases.

// File: rtl/tdmq_pkg.sv
package tdmq_pkg;

    localparam int BYTE_W      = 8;
    localparam int N_QUADS     = 4;
    localparam int QCODE_W     = 3;
    localparam int CTRL_W      = N_QUADS * QCODE_W;
    localparam int QSHIFT_BASE = 3;   // log2 of quadrant size at lowest rate
    localparam int FRAME_BASE  = 5;   // log2 of frame length at lowest rate

    typedef enum logic [1:0] {
        RATE_LOW  = 2'd0,
        RATE_MID  = 2'd1,
        RATE_HIGH = 2'd2,
        RATE_TOP  = 2'd3
    } rate_e;

    typedef struct packed {
        logic       hit;
        logic [1:0] quad;
    } qsel_t;

    typedef struct packed {
        logic en;
        logic lsb_side;
        logic level;
    } force_t;

    function automatic force_t decode_code(input logic [QCODE_W-1:0] code);
        force_t f;
        f.en       = code[2];
        f.lsb_side = code[1];
        f.level    = code[0];
        return f;
    endfunction

    function automatic logic [BYTE_W-1:0] apply_force(input force_t f,
                                                      input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        r = b;
        if (f.en) begin
            if (f.lsb_side) r[0]        = f.level;
            else            r[BYTE_W-1] = f.level;
        end
        return r;
    endfunction

endpackage

// File: rtl/tdmq_ctrl_bank.sv
module tdmq_ctrl_bank
    import tdmq_pkg::*;
#(
    parameter int             N_STREAMS = 32,
    parameter int             ADDR_W    = 16,
    parameter int             REG_W     = 16,
    parameter logic [15:0]    BASE_ADDR = 16'h0120,
    localparam int            IDX_W     = $clog2(N_STREAMS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [REG_W-1:0]  wdata,
    input  logic              re,
    output logic [REG_W-1:0]  rdata,
    input  logic [IDX_W-1:0]  sel_stream,
    output logic [CTRL_W-1:0] sel_ctrl
);

    logic [CTRL_W-1:0] ctrl_q [N_STREAMS];
    logic [ADDR_W-1:0] offset;
    logic              in_window;
    logic [IDX_W-1:0]  idx;
    logic              unused_wdata_hi;

    assign offset          = addr - ADDR_W'(BASE_ADDR);
    assign in_window       = (addr >= ADDR_W'(BASE_ADDR)) && (offset < ADDR_W'(N_STREAMS));
    assign idx             = offset[IDX_W-1:0];
    assign unused_wdata_hi = ^wdata[REG_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_STREAMS; s++) ctrl_q[s] <= '0;
        end else if (we && in_window) begin
            ctrl_q[idx] <= wdata[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= in_window ? {{(REG_W-CTRL_W){1'b0}}, ctrl_q[idx]} : '0;
        end
    end

    assign sel_ctrl = ctrl_q[sel_stream];

endmodule

// File: rtl/tdmq_quad_map.sv
module tdmq_quad_map
    import tdmq_pkg::*;
#(
    parameter int CHAN_W = 8
) (
    input  logic [CHAN_W-1:0] chan,
    input  rate_e             rate,
    output qsel_t             qsel
);

    logic [CHAN_W:0]   frame_len;
    logic [CHAN_W-1:0] scaled;

    always_comb begin
        frame_len = (CHAN_W+1)'(1) << (FRAME_BASE + int'(rate));
        scaled    = chan >> (QSHIFT_BASE + int'(rate));
        qsel.hit  = ({1'b0, chan} < frame_len);
        qsel.quad = scaled[1:0];
    end

endmodule

// File: rtl/tdmq_bit_force.sv
module tdmq_bit_force
    import tdmq_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  qsel_t             qsel,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out
);

    logic [QCODE_W-1:0] codes [N_QUADS];

    for (genvar q = 0; q < N_QUADS; q++) begin : g_split
        assign codes[q] = ctrl[q*QCODE_W +: QCODE_W];
    end

    always_comb begin
        if (qsel.hit) byte_out = apply_force(decode_code(codes[qsel.quad]), byte_in);
        else          byte_out = byte_in;
    end

endmodule

// File: rtl/tdmq_bit_override.sv
module tdmq_bit_override
    import tdmq_pkg::*;
#(
    parameter int          N_STREAMS = 32,
    parameter int          ADDR_W    = 16,
    parameter int          REG_W     = 16,
    parameter int          CHAN_W    = 8,
    parameter logic [15:0] BASE_ADDR = 16'h0120,
    localparam int         SID_W     = $clog2(N_STREAMS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_re,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              in_vld,
    input  logic [SID_W-1:0]  in_stream,
    input  logic [CHAN_W-1:0] in_chan,
    input  logic [1:0]        in_rate,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte
);

    logic [CTRL_W-1:0] cur_ctrl;
    qsel_t             cur_qsel;
    logic [BYTE_W-1:0] next_byte;

    tdmq_ctrl_bank #(
        .N_STREAMS (N_STREAMS),
        .ADDR_W    (ADDR_W),
        .REG_W     (REG_W),
        .BASE_ADDR (BASE_ADDR)
    ) bank_i (
        .clk        (clk),
        .rst        (rst),
        .addr       (reg_addr),
        .we         (reg_we),
        .wdata      (reg_wdata),
        .re         (reg_re),
        .rdata      (reg_rdata),
        .sel_stream (in_stream),
        .sel_ctrl   (cur_ctrl)
    );

    tdmq_quad_map #(.CHAN_W(CHAN_W)) map_i (
        .chan (in_chan),
        .rate (rate_e'(in_rate)),
        .qsel (cur_qsel)
    );

    tdmq_bit_force force_i (
        .ctrl     (cur_ctrl),
        .qsel     (cur_qsel),
        .byte_in  (in_byte),
        .byte_out (next_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_byte <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_byte <= next_byte;
        end
    end

endmodule

// File: rtl/tdmq_bit_override_chk.sv
module tdmq_bit_override_chk
    import tdmq_pkg::*;
#(
    parameter int CHAN_W = 8,
    parameter int REG_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [CHAN_W-1:0] in_chan,
    input logic [1:0]        in_rate,
    input logic [BYTE_W-1:0] in_byte,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              out_vld,
    input logic [BYTE_W-1:0] out_byte
);

    logic [CHAN_W:0] lim;
    logic            beyond;
    assign lim    = (CHAN_W+1)'(32) << in_rate;
    assign beyond = ({1'b0, in_chan} >= lim);

    AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld); // R10
    AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld); // R10
    AST_MID_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_byte[6:1] == $past(in_byte[6:1])); // R6
    AST_BEYOND_FRAME_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_vld && beyond) |=> out_byte == $past(in_byte)); // R9
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:CTRL_W] == '0); // R2
    AST_HELD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> $stable(out_byte)); // R10

endmodule

bind tdmq_bit_override tdmq_bit_override_chk #(.CHAN_W(CHAN_W), .REG_W(REG_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_chan   (in_chan),
    .in_rate   (in_rate),
    .in_byte   (in_byte),
    .reg_rdata (reg_rdata),
    .out_vld   (out_vld),
    .out_byte  (out_byte)
);

// File: tb/tdmq_bit_override_tb_top.sv
module tdmq_bit_override_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_re = 1'b0;
    logic [15:0] reg_rdata;
    logic        in_vld = 1'b0;
    logic [4:0]  in_stream = '0;
    logic [7:0]  in_chan = '0;
    logic [1:0]  in_rate = '0;
    logic [7:0]  in_byte = '0;
    logic        out_vld;
    logic [7:0]  out_byte;

    int checks = 0;
    int fails  = 0;
    logic [11:0] shadow [32];
    bit done = 1'b0;

    always #10 clk = ~clk;

    tdmq_bit_override dut_i (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_re(reg_re), .reg_rdata(reg_rdata),
        .in_vld(in_vld), .in_stream(in_stream), .in_chan(in_chan),
        .in_rate(in_rate), .in_byte(in_byte),
        .out_vld(out_vld), .out_byte(out_byte)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model(input logic [11:0] w, input int ch,
                                         input int rate, input logic [7:0] b);
        logic [7:0] r;
        logic [2:0] c;
        int q;
        r = b;
        if (ch >= (32 << rate)) return r;
        q = (ch >> (3 + rate)) & 3;
        c = w[3*q +: 3];
        if (c[2]) begin
            if (c[1]) r[0] = c[0];
            else      r[7] = c[0];
        end
        return r;
    endfunction

    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (a >= 16'h0120 && a <= 16'h013F) shadow[a - 16'h0120] = d[11:0];
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic xfer(input string req, input int s, input int ch, input int rate,
                        input logic [7:0] b);
        @(negedge clk);
        in_vld = 1'b1; in_stream = 5'(s); in_chan = 8'(ch); in_rate = 2'(rate); in_byte = b;
        @(negedge clk);
        in_vld = 1'b0;
        check({req, " vld"}, {15'd0, out_vld}, 16'd1);
        check(req, {8'd0, out_byte}, {8'd0, model(shadow[s], ch, rate, b)});
    endtask

    task automatic t_reset();
        logic [15:0] d;
        check("R1 out_vld", {15'd0, out_vld}, 16'd0);
        rd(16'h0120, d); check("R1 rd first", d, 16'h0000);
        rd(16'h013F, d); check("R1 rd last", d, 16'h0000);
        xfer("R1 passthru", 0, 0, 0, 8'hA5);
    endtask

    task automatic t_regs();
        logic [15:0] d;
        for (int s = 0; s < 32; s++) wr(16'h0120 + 16'(s), 16'hF000 | 16'((s * 16'h0135) ^ 16'h0A5C));
        for (int s = 0; s < 32; s++) begin
            rd(16'h0120 + 16'(s), d);
            check("R2 readback", d, {4'd0, shadow[s]});
        end
        for (int s = 0; s < 32; s++) wr(16'h0120 + 16'(s), 16'h0000);
    endtask

    task automatic t_outside();
        logic [15:0] d;
        wr(16'h0120 + 16'd31, 16'h0ABC);
        wr(16'h011F, 16'h0FFF);
        rd(16'h011F, d); check("R3 below window", d, 16'h0000);
        wr(16'h0140, 16'h0123);
        rd(16'h0140, d); check("R3 above window", d, 16'h0000);
        rd(16'h0120 + 16'd31, d); check("R3 stream31 intact", d, 16'h0ABC);
        rd(16'h0120, d); check("R3 stream0 intact", d, 16'h0000);
        wr(16'h0120 + 16'd31, 16'h0000);
    endtask

    task automatic t_codes();
        for (int c = 0; c < 8; c++) begin
            wr(16'h0123, 16'(c));
            xfer(c[2] ? (c[1] ? "R7 lsb code" : "R6 msb code") : "R5 pass code", 3, 2, 0, 8'h00);
            xfer(c[2] ? (c[1] ? "R7 lsb code" : "R6 msb code") : "R5 pass code", 3, 5, 0, 8'hFF);
            xfer(c[2] ? (c[1] ? "R7 lsb code" : "R6 msb code") : "R5 pass code", 3, 7, 0, 8'h5A);
        end
        xfer("R11 other stream", 4, 2, 0, 8'h00);
        wr(16'h0123, 16'h0000);
    endtask

    task automatic t_quadrants();
        // q0: MSB=1, q1: LSB=1, q2: MSB=0, q3: LSB=0
        wr(16'h0127, {4'd0, 3'b110, 3'b100, 3'b111, 3'b101});
        for (int r = 0; r < 4; r++) begin
            for (int q = 0; q < 4; q++) begin
                int sz = 8 << r;
                xfer("R4 R8 first", 7, q * sz, r, 8'h42);
                xfer("R4 R8 last", 7, q * sz + sz - 1, r, 8'hC3);
            end
        end
    endtask

    task automatic t_range();
        xfer("R9 rate0 ch32", 7, 32, 0, 8'h42);
        xfer("R9 rate0 ch200", 7, 200, 0, 8'hC3);
        xfer("R9 rate1 ch64", 7, 64, 1, 8'h42);
        xfer("R9 rate2 ch128", 7, 128, 2, 8'hC3);
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_vld = 1'b1; in_stream = 5'd7; in_chan = 8'd0; in_rate = 2'd0; in_byte = 8'h11;
        @(negedge clk);
        check("R10 b2b first", {8'd0, out_byte}, {8'd0, model(shadow[7], 0, 0, 8'h11)});
        in_chan = 8'd9; in_byte = 8'h22;
        @(negedge clk);
        check("R10 b2b second", {8'd0, out_byte}, {8'd0, model(shadow[7], 9, 0, 8'h22)});
        in_vld = 1'b0; in_byte = 8'h77;
        @(negedge clk);
        check("R10 idle vld", {15'd0, out_vld}, 16'd0);
        check("R10 idle hold", {8'd0, out_byte}, {8'd0, model(shadow[7], 9, 0, 8'h22)});
    endtask

    task automatic t_same_edge();
        wr(16'h0128, 16'h0000);
        @(negedge clk);
        reg_addr = 16'h0128; reg_wdata = 16'h0005; reg_we = 1'b1;
        in_vld = 1'b1; in_stream = 5'd8; in_chan = 8'd1; in_rate = 2'd0; in_byte = 8'h01;
        @(negedge clk);
        reg_we = 1'b0;
        check("R11 same edge old word", {8'd0, out_byte}, 16'h0001);
        shadow[8] = 12'h005;
        @(negedge clk);
        in_vld = 1'b0;
        check("R11 next strobe new word", {8'd0, out_byte}, 16'h0081);
    endtask

    initial begin
        for (int s = 0; s < 32; s++) shadow[s] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_outside();
        t_codes();
        t_quadrants();
        t_range();
        t_latency();
        t_same_edge();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=hung exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule